// File: doc/BRIEF.md
# Triple Programmable Down-Counter Timer

This block holds three independent 32-bit down-counters behind one memory-mapped register port. Each counter has a limit, a live count, an 8-bit control word and a sticky raw interrupt flag. Each counter drives its own interrupt line. The top level supplies one clock-enable tick per counter. A per-counter prescaler passes every tick, one in 16, or one in 256. The count drops by one on each tick that the prescaler lets through.

When a count runs out, the raw flag is set and the counter acts by its mode. In one-shot mode it parks at zero. In periodic mode it reloads from the limit. In free-running mode it wraps to the top of a 16-bit or 32-bit range. Software restarts a counter by writing the load register. It queues a new period without disturbing the live count by writing the background-load register. The bus is a single-cycle port: a write completes at the clock edge where the strobe is high, and read data is combinational from the word address.

Top module: `tri_down_timer`

## Requirements
- R1: The word address carries the counter number in bits [7:6] and the register index in bits [5:0]. Index 0 is load, 1 is value, 2 is control, 3 is clear, 4 is raw status, 5 is masked status and 6 is background load. A write to counter number 3 changes nothing. A read of counter number 3, or of any unused index, returns 0.
- R2: The control word sits in bits [7:0]. Bit 7 enables counting, bit 6 selects periodic mode, bit 5 enables the interrupt, bits [3:2] hold the prescale code, bit 1 selects 32-bit wrap and bit 0 selects one-shot mode. After reset every control word reads 0x20, every count reads 0xFFFFFFFF, every limit reads 0 and every interrupt line is low.
- R3: An enabled counter decrements by one on each prescaled tick. A disabled counter holds its count and returns it when read.
- R4: Prescale code 1 passes one tick in 16 and code 2 passes one tick in 256. Codes 0 and 3 pass every tick. Writing load or control restarts the prescaler.
- R5: A prescaled tick that finds the count at 1 (or at 0, outside one-shot mode) is an expiry and sets the raw flag, which reads as bit 0 of the raw status. In periodic mode the count then reloads from the limit.
- R6: On expiry in free-running mode (bits 6 and 0 clear), the count becomes 0xFFFF when bit 1 is clear and 0xFFFFFFFF when bit 1 is set.
- R7: On expiry in one-shot mode the count becomes 0. A one-shot counter at 0 stays at 0 and raises no further expiry.
- R8: A write to load sets both the limit and the count. A write to background load sets only the limit. Both indices read back the limit.
- R9: Any write to the clear index clears the raw flag, unless an expiry happens on the same edge.
- R10: The masked status reads 0 when control bit 5 is clear and reads the raw flag otherwise. Each interrupt line is the registered AND of its raw flag and bit 5, and it lags them by one clock.
- R11: Writes to the value index have no effect on the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 3 | Per-counter clock-enable tick |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 8 | Word address: counter number [7:6], register index [5:0] |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data |
| irq | output | 3 | Registered per-counter interrupt lines |

## Verification
The assertions assume that the write strobe, the address and the ticks are stable, known values at every rising edge after reset. The hold and stability properties also assume that no other write to the same counter arrives in the cycle under check. The stimulus changes inputs only on falling edges and issues at most one write per cycle. It keeps the tick lines low during register writes, so each property sees either a write or a tick on a counter, never both.

// File: rtl/dtmr_pkg.sv
package dtmr_pkg;

    localparam int DATA_W  = 32;
    localparam int SEL_W   = 2;
    localparam int IDX_W   = 6;
    localparam int ADDR_W  = SEL_W + IDX_W;
    localparam int PRE_W   = 8;

    typedef enum logic [IDX_W-1:0] {
        IDX_LOAD   = 6'd0,
        IDX_VALUE  = 6'd1,
        IDX_CTRL   = 6'd2,
        IDX_CLEAR  = 6'd3,
        IDX_RAW    = 6'd4,
        IDX_MASKED = 6'd5,
        IDX_BGLOAD = 6'd6
    } reg_idx_e;

    typedef enum logic [1:0] {
        PRE_DIV1   = 2'd0,
        PRE_DIV16  = 2'd1,
        PRE_DIV256 = 2'd2,
        PRE_DIV1B  = 2'd3
    } prescale_e;

    typedef struct packed {
        logic      run;
        logic      periodic;
        logic      irq_on;
        logic      spare;
        prescale_e pre;
        logic      wide;
        logic      single;
    } ctrl_t;

    localparam ctrl_t CTRL_RESET = '{run: 1'b0, periodic: 1'b0, irq_on: 1'b1,
                                     spare: 1'b0, pre: PRE_DIV1, wide: 1'b0,
                                     single: 1'b0};

    function automatic logic [DATA_W-1:0] wrap_value(input logic wide);
        wrap_value = wide ? {DATA_W{1'b1}} : {{(DATA_W-16){1'b0}}, 16'hFFFF};
    endfunction

endpackage

// File: rtl/dtmr_prescale.sv
module dtmr_prescale
    import dtmr_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      tick_in,
    input  logic      enable,
    input  logic      restart,
    input  prescale_e code,
    output logic      tick_out
);
    logic [PRE_W-1:0] phase_q;
    logic             wrap_hit;

    always_comb begin
        unique case (code)
            PRE_DIV16:  wrap_hit = (phase_q[3:0] == 4'hF);
            PRE_DIV256: wrap_hit = (phase_q == {PRE_W{1'b1}});
            default:    wrap_hit = 1'b1;
        endcase
    end

    assign tick_out = tick_in && enable && wrap_hit;

    always_ff @(posedge clk) begin
        if (rst || restart)
            phase_q <= '0;
        else if (tick_in && enable)
            phase_q <= phase_q + 1'b1;
    end
endmodule

// File: rtl/dtmr_channel.sv
module dtmr_channel
    import dtmr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              wr_load,
    input  logic              wr_ctrl,
    input  logic              wr_clear,
    input  logic              wr_bg,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] count,
    output logic [DATA_W-1:0] limit,
    output ctrl_t             ctrl,
    output logic              raw
);
    logic              parked;
    logic              active;
    logic              expire;
    logic [DATA_W-1:0] count_next;

    assign parked = ctrl.single && (count == '0);
    assign active = tick && ctrl.run && !parked && !wr_load;
    assign expire = (count <= DATA_W'(1));

    always_comb begin
        if (!expire)
            count_next = count - 1'b1;
        else if (ctrl.single)
            count_next = '0;
        else if (ctrl.periodic)
            count_next = limit;
        else
            count_next = wrap_value(ctrl.wide);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl  <= CTRL_RESET;
            count <= '1;
            limit <= '0;
            raw   <= 1'b0;
        end else begin
            if (wr_ctrl)
                ctrl <= ctrl_t'(wdata[7:0]);
            if (wr_load || wr_bg)
                limit <= wdata;
            if (wr_load)
                count <= wdata;
            else if (active)
                count <= count_next;
            if (active && expire)
                raw <= 1'b1;
            else if (wr_clear)
                raw <= 1'b0;
        end
    end
endmodule

// File: rtl/tri_down_timer.sv
module tri_down_timer
    import dtmr_pkg::*;
#(
    parameter int N_TMR = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [N_TMR-1:0]  tick_en,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [N_TMR-1:0]  irq
);
    logic [SEL_W-1:0]  sel;
    reg_idx_e          idx;
    logic [DATA_W-1:0] ch_count [N_TMR];
    logic [DATA_W-1:0] ch_limit [N_TMR];
    ctrl_t             ch_ctrl  [N_TMR];
    logic [N_TMR-1:0]  ch_raw;
    logic [N_TMR-1:0]  ch_ptick;
    logic [N_TMR-1:0]  hit;

    assign sel = bus_addr[ADDR_W-1:IDX_W];
    assign idx = reg_idx_e'(bus_addr[IDX_W-1:0]);

    for (genvar i = 0; i < N_TMR; i++) begin : g_ch
        logic wr_any;
        assign hit[i]  = (sel == SEL_W'(i));
        assign wr_any  = bus_wr && hit[i];

        dtmr_prescale u_pre (
            .clk      (clk),
            .rst      (rst),
            .tick_in  (tick_en[i]),
            .enable   (ch_ctrl[i].run),
            .restart  (wr_any && (idx == IDX_LOAD || idx == IDX_CTRL)),
            .code     (ch_ctrl[i].pre),
            .tick_out (ch_ptick[i])
        );

        dtmr_channel u_ch (
            .clk      (clk),
            .rst      (rst),
            .tick     (ch_ptick[i]),
            .wr_load  (wr_any && idx == IDX_LOAD),
            .wr_ctrl  (wr_any && idx == IDX_CTRL),
            .wr_clear (wr_any && idx == IDX_CLEAR),
            .wr_bg    (wr_any && idx == IDX_BGLOAD),
            .wdata    (bus_wdata),
            .count    (ch_count[i]),
            .limit    (ch_limit[i]),
            .ctrl     (ch_ctrl[i]),
            .raw      (ch_raw[i])
        );

        always_ff @(posedge clk) begin
            if (rst)
                irq[i] <= 1'b0;
            else
                irq[i] <= ch_raw[i] && ch_ctrl[i].irq_on;
        end
    end

    always_comb begin
        bus_rdata = '0;
        for (int i = 0; i < N_TMR; i++) begin
            if (hit[i]) begin
                case (idx)
                    IDX_LOAD, IDX_BGLOAD: bus_rdata = ch_limit[i];
                    IDX_VALUE:  bus_rdata = ch_count[i];
                    IDX_CTRL:   bus_rdata = {{(DATA_W-8){1'b0}}, ch_ctrl[i]};
                    IDX_RAW:    bus_rdata = {{(DATA_W-1){1'b0}}, ch_raw[i]};
                    IDX_MASKED: bus_rdata = {{(DATA_W-1){1'b0}},
                                             ch_raw[i] && ch_ctrl[i].irq_on};
                    default:    bus_rdata = '0;
                endcase
            end
        end
    end
endmodule

// File: rtl/dtmr_checker.sv
module dtmr_checker
    import dtmr_pkg::*;
#(
    parameter int N_TMR = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [N_TMR-1:0]  irq,
    input  logic [DATA_W-1:0] ch_count [N_TMR],
    input  ctrl_t             ch_ctrl  [N_TMR],
    input  logic [N_TMR-1:0]  ch_raw,
    input  logic [N_TMR-1:0]  ch_ptick
);
    for (genvar i = 0; i < N_TMR; i++) begin : g_chk
        logic wr_me;
        logic [IDX_W-1:0] widx;
        assign wr_me = bus_wr && (bus_addr[ADDR_W-1:IDX_W] == SEL_W'(i));
        assign widx  = bus_addr[IDX_W-1:0];

        AST_VALUE_WRITE_IGNORED: assert property (@(posedge clk) disable iff (rst)
            (wr_me && widx == IDX_VALUE && !ch_ptick[i]) |=> $stable(ch_count[i])); // R11

        AST_DISABLED_HOLDS: assert property (@(posedge clk) disable iff (rst)
            (!ch_ctrl[i].run && !wr_me) |=> $stable(ch_count[i])); // R3

        AST_ONESHOT_PARKED: assert property (@(posedge clk) disable iff (rst)
            (ch_ctrl[i].single && ch_count[i] == '0 && !wr_me)
            |=> (ch_count[i] == '0 && !$rose(ch_raw[i]))); // R7

        AST_CLEAR_DROPS_RAW: assert property (@(posedge clk) disable iff (rst)
            (wr_me && widx == IDX_CLEAR && !ch_ptick[i]) |=> !ch_raw[i]); // R9

        AST_FREERUN_WRAP: assert property (@(posedge clk) disable iff (rst)
            (ch_ptick[i] && !wr_me && ch_count[i] == DATA_W'(1) &&
             !ch_ctrl[i].single && !ch_ctrl[i].periodic)
            |=> (ch_count[i] == wrap_value($past(ch_ctrl[i].wide)) && ch_raw[i])); // R6

        AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (rst)
            !ch_ctrl[i].irq_on |=> !irq[i]); // R10
    end
endmodule

bind tri_down_timer dtmr_checker #(.N_TMR(N_TMR)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .irq      (irq),
    .ch_count (ch_count),
    .ch_ctrl  (ch_ctrl),
    .ch_raw   (ch_raw),
    .ch_ptick (ch_ptick)
);

// File: tb/tri_down_timer_test.sv
module tri_down_timer_test;
    import dtmr_pkg::*;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [2:0]        tick_en = '0;
    logic              bus_wr = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [DATA_W-1:0] bus_wdata = '0;
    logic [DATA_W-1:0] bus_rdata;
    logic [2:0]        irq;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    tri_down_timer uut (
        .clk       (clk),
        .rst       (rst),
        .tick_en   (tick_en),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq       (irq)
    );

    // Vector fields: req[45:42] op[41:40] timer[39:38] index[37:32] data[31:0]
    // op 0 = write, 1 = read and compare, 2 = tick count, 3 = wait a clock then compare irq
    localparam int NV = 52;
    localparam logic [45:0] VEC [NV] = '{
        {4'd8,  2'd0, 2'd1, 6'd0, 32'd5},          // R8 load timer1 with 5
        {4'd2,  2'd0, 2'd1, 6'd2, 32'h0000_00E0},  // R2 run, periodic, irq on
        {4'd8,  2'd1, 2'd1, 6'd1, 32'd5},          // R8 count taken from load
        {4'd3,  2'd2, 2'd1, 6'd0, 32'd4},
        {4'd3,  2'd1, 2'd1, 6'd1, 32'd1},          // R3 four ticks
        {4'd5,  2'd1, 2'd1, 6'd4, 32'd0},          // R5 no expiry yet
        {4'd5,  2'd2, 2'd1, 6'd0, 32'd1},
        {4'd5,  2'd1, 2'd1, 6'd1, 32'd5},          // R5 periodic reload
        {4'd5,  2'd1, 2'd1, 6'd4, 32'd1},          // R5 raw set
        {4'd10, 2'd1, 2'd1, 6'd5, 32'd1},          // R10 masked equals raw
        {4'd10, 2'd3, 2'd0, 6'd0, 32'b010},        // R10 irq line
        {4'd9,  2'd0, 2'd1, 6'd3, 32'hDEAD},       // R9 clear
        {4'd9,  2'd1, 2'd1, 6'd4, 32'd0},          // R9 raw gone
        {4'd10, 2'd3, 2'd0, 6'd0, 32'b000},        // R10 irq follows
        {4'd8,  2'd0, 2'd1, 6'd6, 32'd9},          // R8 background load
        {4'd8,  2'd1, 2'd1, 6'd0, 32'd9},          // R8 load reads limit
        {4'd8,  2'd1, 2'd1, 6'd6, 32'd9},          // R8 bgload reads limit
        {4'd8,  2'd1, 2'd1, 6'd1, 32'd5},          // R8 count untouched
        {4'd5,  2'd2, 2'd1, 6'd0, 32'd5},
        {4'd5,  2'd1, 2'd1, 6'd1, 32'd9},          // R5 reload uses new limit
        {4'd9,  2'd0, 2'd1, 6'd3, 32'd0},          // R9 clear timer1 again
        {4'd7,  2'd0, 2'd0, 6'd0, 32'd2},          // R7 one-shot on timer0
        {4'd7,  2'd0, 2'd0, 6'd2, 32'h0000_00A1},
        {4'd7,  2'd2, 2'd0, 6'd0, 32'd2},
        {4'd7,  2'd1, 2'd0, 6'd1, 32'd0},          // R7 parked at 0
        {4'd7,  2'd1, 2'd0, 6'd4, 32'd1},          // R7 raw set
        {4'd10, 2'd3, 2'd0, 6'd0, 32'b001},        // R10 irq timer0
        {4'd7,  2'd0, 2'd0, 6'd3, 32'd1},
        {4'd7,  2'd2, 2'd0, 6'd0, 32'd3},
        {4'd7,  2'd1, 2'd0, 6'd1, 32'd0},          // R7 still 0
        {4'd7,  2'd1, 2'd0, 6'd4, 32'd0},          // R7 no new expiry
        {4'd6,  2'd0, 2'd2, 6'd0, 32'd1},          // R6 free run 16-bit
        {4'd6,  2'd0, 2'd2, 6'd2, 32'h0000_0080},
        {4'd6,  2'd2, 2'd2, 6'd0, 32'd1},
        {4'd6,  2'd1, 2'd2, 6'd1, 32'h0000_FFFF},  // R6 16-bit wrap
        {4'd10, 2'd1, 2'd2, 6'd5, 32'd0},          // R10 masked with bit5 clear
        {4'd10, 2'd3, 2'd0, 6'd0, 32'b000},        // R10 irq held low
        {4'd6,  2'd0, 2'd2, 6'd0, 32'd1},
        {4'd6,  2'd0, 2'd2, 6'd2, 32'h0000_0082},
        {4'd6,  2'd2, 2'd2, 6'd0, 32'd1},
        {4'd6,  2'd1, 2'd2, 6'd1, 32'hFFFF_FFFF},  // R6 32-bit wrap
        {4'd4,  2'd0, 2'd1, 6'd0, 32'd3},          // R4 divide by 16
        {4'd4,  2'd0, 2'd1, 6'd2, 32'h0000_0084},
        {4'd4,  2'd2, 2'd1, 6'd0, 32'd15},
        {4'd4,  2'd1, 2'd1, 6'd1, 32'd3},          // R4 held for 15
        {4'd4,  2'd2, 2'd1, 6'd0, 32'd1},
        {4'd4,  2'd1, 2'd1, 6'd1, 32'd2},          // R4 16th tick counts
        {4'd11, 2'd0, 2'd1, 6'd1, 32'd7},          // R11 value write
        {4'd11, 2'd1, 2'd1, 6'd1, 32'd2},          // R11 ignored
        {4'd3,  2'd0, 2'd1, 6'd2, 32'h0000_0000},  // R3 disable
        {4'd3,  2'd2, 2'd1, 6'd0, 32'd5},
        {4'd3,  2'd1, 2'd1, 6'd1, 32'd2}           // R3 held
    };

    task automatic check(input int req, input logic [DATA_W-1:0] act,
                         input logic [DATA_W-1:0] exp, input string what);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL R%0d %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic do_write(input int t, input int ix, input logic [DATA_W-1:0] d);
        @(negedge clk);
        bus_wr    = 1'b1;
        bus_addr  = {SEL_W'(t), IDX_W'(ix)};
        bus_wdata = d;
        @(negedge clk);
        bus_wr    = 1'b0;
    endtask

    task automatic do_read(input int req, input int t, input int ix,
                           input logic [DATA_W-1:0] exp);
        bus_addr = {SEL_W'(t), IDX_W'(ix)};
        #1;
        check(req, bus_rdata, exp, $sformatf("read t%0d idx%0d", t, ix));
    endtask

    task automatic do_ticks(input int t, input int n);
        @(negedge clk);
        tick_en = 3'(1 << t);
        repeat (n) @(negedge clk);
        tick_en = '0;
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R2: reset state of every counter
        for (int t = 0; t < 3; t++) begin
            do_read(2, t, 2, 32'h20);
            do_read(2, t, 1, 32'hFFFF_FFFF);
            do_read(2, t, 0, 32'd0);
        end
        check(2, {29'd0, irq}, 32'd0, "irq after reset");

        for (int v = 0; v < NV; v++) begin
            logic [45:0] e;
            int rq;
            e  = VEC[v];
            rq = int'(e[45:42]);
            case (e[41:40])
                2'd0: do_write(int'(e[39:38]), int'(e[37:32]), e[31:0]);
                2'd1: do_read(rq, int'(e[39:38]), int'(e[37:32]), e[31:0]);
                2'd2: do_ticks(int'(e[39:38]), int'(e[31:0]));
                default: begin
                    @(negedge clk);
                    check(rq, {29'd0, irq}, e[31:0], "irq lines");
                end
            endcase
        end

        // R4: divide by 256 on timer0
        do_write(0, 0, 32'd2);
        do_write(0, 2, 32'h88);
        do_ticks(0, 255);
        do_read(4, 0, 1, 32'd2);
        do_ticks(0, 1);
        do_read(4, 0, 1, 32'd1);

        // R1: counter number 3 and unused index
        do_write(3, 0, 32'h55);
        do_read(1, 3, 0, 32'd0);
        do_read(1, 0, 0, 32'd2);
        do_read(1, 1, 0, 32'd3);
        do_read(1, 2, 9, 32'd0);

        // R5: a loaded zero in periodic mode expires on the next tick
        do_write(1, 6, 32'd4);
        do_write(1, 0, 32'd0);
        do_write(1, 6, 32'd4);
        do_write(1, 2, 32'hC0);
        do_ticks(1, 1);
        do_read(5, 1, 1, 32'd4);
        do_read(5, 1, 4, 32'd1);

        // R2: reset mid-run restores defaults
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        do_read(2, 1, 2, 32'h20);
        do_read(2, 1, 1, 32'hFFFF_FFFF);
        do_read(2, 2, 4, 32'd0);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual=timeout expected=done");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end
endmodule